// File: doc/BRIEF.md
# Video Sync Timing Measurement Unit

This block watches the horizontal sync, vertical sync and data-enable signals of an incoming video stream and measures, for both axes, the width of the sync pulse, the back porch, the active region and the front porch. Horizontal intervals are counted in pixel ticks, where a pixel tick is one clock cycle in which `pix_ce` is high. Vertical intervals are counted in lines, where one line runs from one horizontal sync rising edge to the next. The whole block runs on one clock, which is also the register-bus clock. Pixel timing enters only through the `pix_ce` qualifier, so the block needs no clock-domain crossing.

Software sets the block up and reads the results through a small word-addressed register port. A write takes effect at the clock edge where `reg_wr` is high, and read data follows `reg_addr` combinationally. Each latched result is compared with the value it replaces. A difference sets a sticky interrupt-status bit, and an enable mask selects which of these bits drive the interrupt line. A separate timer counts bus cycles while horizontal sync is inactive and flags a stalled line source. Results can be refreshed once per frame or, for the horizontal set, once per line.

Top module: `vtm_top`

## Requirements
- R1: After reset, control reads 0x00, the interrupt mask reads 0xFF, the stall limit reads 0x1FFF, status, interrupt status and all eight results read 0, and `irq_o` is low.
- R2: Horizontal results are in pixel ticks. Sync width covers the ticks from the sync rising edge up to the tick before its falling edge. Back porch runs from there to the first tick with data-enable high. Active covers the ticks with data-enable high. Front porch runs from the tick after active to the next sync rising edge.
- R3: Vertical results are in lines and use the same four phases. A line counts as in sync if vsync is active during it, and as active if data-enable was high in any of its pixels.
- R4: Control bit 0 set means hsync is active low, and control bit 1 set means vsync is active low. Measured values do not depend on polarity once it matches the input.
- R5: With control bit 4 clear, all eight results are replaced only when a frame completes, that is at a vertical sync rising edge that follows a full front porch. Lines inside a frame leave the horizontal results unchanged.
- R6: With control bit 4 set, the four horizontal results are replaced at every completed line, and the vertical results still change only per frame.
- R7: Interrupt-status bit k (k=0..3: vertical sync, back porch, active, front porch; k=4..7: the same four horizontal) is set when a refresh writes a value different from the held one. Writing 1 to a bit clears it. A refresh that repeats the held values sets nothing.
- R8: `irq_o` is high, one cycle after the registers change, exactly when control bit 3 is set and some interrupt-status bit is set whose mask bit is also set.
- R9: Status bit 0 is set once the corrected hsync has been inactive for more than the stall limit of consecutive clock cycles. The bit stays set until 1 is written to it. An inactive run of exactly the limit does not set it.
- R10: A write of 0 to the stall limit is ignored, and a write of any other value is stored.
- R11: With control bit 2 (measure enable) clear, all interval counters and the stall counter are held cleared and status bit 1 reads 0.
- R12: Status bit 1 goes to 1 at the first frame completion after measurement is enabled. A single frame after enabling is not enough.
- R13: Word offsets are: interrupt status 0x00, vertical sync/back/active/front 0x04/0x08/0x0C/0x10, horizontal sync/back/active/front 0x14/0x18/0x1C/0x20, control 0x24, interrupt mask 0x28, stall limit 0x2C, status 0x30. Writes to result registers are ignored, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel tick qualifier; sync and data-enable are sampled when high |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| de_in | input | 1 | Data-enable marking active pixels |
| reg_addr | input | ADDR_W (6) | Byte address of the register word |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that the sync and data-enable inputs change only in cycles that are then sampled by `pix_ce`, and that vertical sync changes together with the first pixel of a line. The measurement phases rely on this alignment. They also assume a well-formed video stream in which each phase ends in order before the next begins. The bench builds every line from one task that drives each input at a falling clock edge together with a `pix_ce` pulse, so every stimulus meets these assumptions. After a change of polarity the bench runs three full frames before it checks anything, so that the edge history left over from the old polarity has been flushed.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SYNC,
      PH_BACK,
      PH_ACT,
      PH_FRONT
   } vtm_phase_e;

   // slot order inside a result set, also the interrupt bit order per axis
   localparam int unsigned SLOT_SYNC  = 0;
   localparam int unsigned SLOT_BACK  = 1;
   localparam int unsigned SLOT_ACT   = 2;
   localparam int unsigned SLOT_FRONT = 3;
   localparam int unsigned NUM_SLOTS  = 4;

   // register word indices (byte offset / 4)
   localparam int unsigned W_IST    = 0;
   localparam int unsigned W_VSYNC  = 1;
   localparam int unsigned W_VBACK  = 2;
   localparam int unsigned W_VACT   = 3;
   localparam int unsigned W_VFRONT = 4;
   localparam int unsigned W_HSYNC  = 5;
   localparam int unsigned W_HBACK  = 6;
   localparam int unsigned W_HACT   = 7;
   localparam int unsigned W_HFRONT = 8;
   localparam int unsigned W_CTRL   = 9;
   localparam int unsigned W_MASK   = 10;
   localparam int unsigned W_LIMIT  = 11;
   localparam int unsigned W_STAT   = 12;

   // control bit positions
   localparam int unsigned C_HINV   = 0;
   localparam int unsigned C_VINV   = 1;
   localparam int unsigned C_EN     = 2;
   localparam int unsigned C_IRQEN  = 3;
   localparam int unsigned C_LINE   = 4;
   localparam int unsigned CTRL_W   = 5;

endpackage

// File: rtl/vtm_sync_cond.sv
module vtm_sync_cond #(
   parameter bit IN_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pix_ce,
   input  logic hsync_raw,
   input  logic vsync_raw,
   input  logic de_raw,
   input  logic inv_h,
   input  logic inv_v,
   output logic hs_lvl,
   output logic pix_tick,
   output logic h_de,
   output logic line_tick,
   output logic v_sync_line,
   output logic v_de_line
);

   logic s_pix, s_hs, s_vs, s_de;
   logic vs_lvl, hs_prev, vs_prev, had_de;

   generate
      if (IN_REG) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_pix <= 1'b0;
               s_hs  <= 1'b0;
               s_vs  <= 1'b0;
               s_de  <= 1'b0;
            end else begin
               s_pix <= pix_ce;
               s_hs  <= hsync_raw;
               s_vs  <= vsync_raw;
               s_de  <= de_raw;
            end
         end
      end else begin : g_in_direct
         assign s_pix = pix_ce;
         assign s_hs  = hsync_raw;
         assign s_vs  = vsync_raw;
         assign s_de  = de_raw;
      end
   endgenerate

   assign hs_lvl    = s_hs ^ inv_h;
   assign vs_lvl    = s_vs ^ inv_v;
   assign pix_tick  = s_pix;
   assign h_de      = s_de;
   assign line_tick = s_pix & hs_lvl & ~hs_prev;

   // vertical levels describe the line that just ended
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev <= 1'b0;
         vs_prev <= 1'b0;
         had_de  <= 1'b0;
      end else if (clr) begin
         hs_prev <= 1'b0;
         vs_prev <= 1'b0;
         had_de  <= 1'b0;
      end else if (s_pix) begin
         hs_prev <= hs_lvl;
         vs_prev <= vs_lvl;
         had_de  <= line_tick ? s_de : (had_de | s_de);
      end
   end

   assign v_sync_line = vs_prev;
   assign v_de_line   = had_de;

endmodule

// File: rtl/vtm_interval_meter.sv
module vtm_interval_meter
   import vtm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clr,
   input  logic                                 step,
   input  logic                                 sync_lvl,
   input  logic                                 de_lvl,
   output logic [NUM_SLOTS-1:0][CNT_W-1:0]      len_o,
   output logic                                 done_o
);

   vtm_phase_e       phase;
   logic             sync_q, de_q;
   logic [CNT_W-1:0] cnt;

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         sync_q <= 1'b0;
         de_q   <= 1'b0;
         cnt    <= '0;
         len_o  <= '0;
         done_o <= 1'b0;
      end else if (clr) begin
         phase  <= PH_IDLE;
         sync_q <= 1'b0;
         de_q   <= 1'b0;
         cnt    <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (step) begin
            sync_q <= sync_lvl;
            de_q   <= de_lvl;
            if (sync_lvl && !sync_q) begin
               if (phase == PH_FRONT) begin
                  len_o[SLOT_FRONT] <= cnt;
                  done_o            <= 1'b1;
               end
               phase <= PH_SYNC;
               cnt   <= CNT_ONE;
            end else if (!sync_lvl && sync_q && phase == PH_SYNC) begin
               len_o[SLOT_SYNC] <= cnt;
               phase <= PH_BACK;
               cnt   <= CNT_ONE;
            end else if (de_lvl && !de_q && phase == PH_BACK) begin
               len_o[SLOT_BACK] <= cnt;
               phase <= PH_ACT;
               cnt   <= CNT_ONE;
            end else if (!de_lvl && de_q && phase == PH_ACT) begin
               len_o[SLOT_ACT] <= cnt;
               phase <= PH_FRONT;
               cnt   <= CNT_ONE;
            end else if (cnt != '1) begin
               cnt <= cnt + CNT_ONE;
            end
         end
      end
   end

   // a completed period is only ever reported on a sampled tick
   assert_done_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(step));

   // holding the counters cleared suppresses any completion
   assert_no_done_in_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !done_o);

endmodule

// File: rtl/vtm_stall_timer.sv
module vtm_stall_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hs_lvl,
   input  logic [TMO_W-1:0] limit,
   input  logic             flag_clr,
   output logic             flag_o
);

   logic [TMO_W-1:0] run_cnt;
   logic             over;

   assign over = !clr && !hs_lvl && (run_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (clr || hs_lvl) begin
         run_cnt <= '0;
      end else if (run_cnt != '1) begin
         run_cnt <= run_cnt + TMO_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (over) begin
         flag_o <= 1'b1;
      end else if (flag_clr) begin
         flag_o <= 1'b0;
      end
   end

   // the stall flag can only appear while hsync is inactive
   assert_flag_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(!hs_lvl));

endmodule

// File: rtl/vtm_top.sv
module vtm_top
   import vtm_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned TMO_W  = 16,
   parameter bit          IN_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_ce,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic              de_in,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);

   localparam int unsigned WORD_W  = ADDR_W - 2;
   localparam int unsigned IRQ_W   = 2 * NUM_SLOTS;
   localparam logic [TMO_W-1:0] LIMIT_RST = TMO_W'(13'h1FFF);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x30");
      end
      if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must be in 4..DATA_W");
      end
      if (TMO_W < 13 || TMO_W >= DATA_W) begin : g_bad_tmo
         $error("TMO_W must hold the reset limit and be below DATA_W");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [IRQ_W-1:0]  mask_q, ist_q, ist_set, ist_clr;
   logic [TMO_W-1:0]  limit_q;
   logic              init_done, stall_flag;
   logic [NUM_SLOTS-1:0][CNT_W-1:0] h_len, v_len, h_res, v_res;
   logic              h_done, v_done, meas_off, h_take, v_take;
   logic              hs_lvl, pix_tick, h_de, line_tick, v_sync_line, v_de_line;
   logic [WORD_W-1:0] word;
   logic              wr_ist, wr_stat;
   logic              unused_bits;

   assign word        = reg_addr[ADDR_W-1:2];
   assign meas_off    = !ctrl_q[C_EN];
   assign wr_ist      = reg_wr && word == WORD_W'(W_IST);
   assign wr_stat     = reg_wr && word == WORD_W'(W_STAT);
   assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:TMO_W]};

   vtm_sync_cond #(.IN_REG(IN_REG)) u_cond (
      .clk(clk), .rst_n(rst_n), .clr(meas_off), .pix_ce(pix_ce),
      .hsync_raw(hsync_in), .vsync_raw(vsync_in), .de_raw(de_in),
      .inv_h(ctrl_q[C_HINV]), .inv_v(ctrl_q[C_VINV]),
      .hs_lvl(hs_lvl), .pix_tick(pix_tick), .h_de(h_de), .line_tick(line_tick),
      .v_sync_line(v_sync_line), .v_de_line(v_de_line)
   );

   vtm_interval_meter #(.CNT_W(CNT_W)) u_hmeter (
      .clk(clk), .rst_n(rst_n), .clr(meas_off), .step(pix_tick),
      .sync_lvl(hs_lvl), .de_lvl(h_de), .len_o(h_len), .done_o(h_done)
   );

   vtm_interval_meter #(.CNT_W(CNT_W)) u_vmeter (
      .clk(clk), .rst_n(rst_n), .clr(meas_off), .step(line_tick),
      .sync_lvl(v_sync_line), .de_lvl(v_de_line), .len_o(v_len), .done_o(v_done)
   );

   vtm_stall_timer #(.TMO_W(TMO_W)) u_stall (
      .clk(clk), .rst_n(rst_n), .clr(meas_off), .hs_lvl(hs_lvl),
      .limit(limit_q), .flag_clr(wr_stat && reg_wdata[0]), .flag_o(stall_flag)
   );

   // refresh selection: per-line horizontal or everything per frame
   assign h_take = ctrl_q[C_LINE] ? h_done : v_done;
   assign v_take = v_done;

   always_comb begin
      ist_set = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         ist_set[k]             = v_take && (v_len[k] != v_res[k]);
         ist_set[NUM_SLOTS + k] = h_take && (h_len[k] != h_res[k]);
      end
      ist_clr = wr_ist ? reg_wdata[IRQ_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         mask_q    <= '1;
         limit_q   <= LIMIT_RST;
         ist_q     <= '0;
         h_res     <= '0;
         v_res     <= '0;
         init_done <= 1'b0;
         irq_o     <= 1'b0;
      end else begin
         if (reg_wr && word == WORD_W'(W_CTRL))  ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (reg_wr && word == WORD_W'(W_MASK))  mask_q <= reg_wdata[IRQ_W-1:0];
         if (reg_wr && word == WORD_W'(W_LIMIT) && reg_wdata[TMO_W-1:0] != '0)
            limit_q <= reg_wdata[TMO_W-1:0];
         ist_q <= (ist_q & ~ist_clr) | ist_set;
         if (h_take) h_res <= h_len;
         if (v_take) v_res <= v_len;
         if (meas_off)    init_done <= 1'b0;
         else if (v_done) init_done <= 1'b1;
         irq_o <= ctrl_q[C_IRQEN] && |(ist_q & mask_q);
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (word)
         WORD_W'(W_IST):    reg_rdata[IRQ_W-1:0] = ist_q;
         WORD_W'(W_VSYNC):  reg_rdata[CNT_W-1:0] = v_res[SLOT_SYNC];
         WORD_W'(W_VBACK):  reg_rdata[CNT_W-1:0] = v_res[SLOT_BACK];
         WORD_W'(W_VACT):   reg_rdata[CNT_W-1:0] = v_res[SLOT_ACT];
         WORD_W'(W_VFRONT): reg_rdata[CNT_W-1:0] = v_res[SLOT_FRONT];
         WORD_W'(W_HSYNC):  reg_rdata[CNT_W-1:0] = h_res[SLOT_SYNC];
         WORD_W'(W_HBACK):  reg_rdata[CNT_W-1:0] = h_res[SLOT_BACK];
         WORD_W'(W_HACT):   reg_rdata[CNT_W-1:0] = h_res[SLOT_ACT];
         WORD_W'(W_HFRONT): reg_rdata[CNT_W-1:0] = h_res[SLOT_FRONT];
         WORD_W'(W_CTRL):   reg_rdata[CTRL_W-1:0] = ctrl_q;
         WORD_W'(W_MASK):   reg_rdata[IRQ_W-1:0] = mask_q;
         WORD_W'(W_LIMIT):  reg_rdata[TMO_W-1:0] = limit_q;
         WORD_W'(W_STAT):   reg_rdata[1:0] = {init_done, stall_flag};
         default:           reg_rdata = '0;
      endcase
   end

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(ctrl_q[C_IRQEN]));

   assert_ist_on_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ist_q & ~$past(ist_q))) |-> $past(h_done || v_done));

   assert_init_on_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(v_done));

   assert_off_clears_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[C_EN] |=> !init_done);

   assert_limit_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      limit_q != '0);

endmodule

// File: tb/test_vtm_top.sv
module test_vtm_top;

   localparam int ADDR_W = 6;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pix_ce = 1'b0;
   logic              hsync_in = 1'b0;
   logic              vsync_in = 1'b0;
   logic              de_in = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit hpol = 1'b0;
   bit vpol = 1'b0;

   always #2.5 clk = ~clk;

   vtm_top i_vtm_top (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
      .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic read_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
      logic [31:0] d;
      reg_read(a, d);
      check(req, d, exp);
   endtask

   task automatic drive_line(input int hs, input int hb, input int ha, input int hf,
                             input bit vs_on, input bit de_on);
      for (int p = 0; p < hs + hb + ha + hf; p++) begin
         @(negedge clk);
         hsync_in = (p < hs) ^ hpol;
         vsync_in = vs_on ^ vpol;
         de_in    = de_on && (p >= hs + hb) && (p < hs + hb + ha);
         pix_ce   = 1'b1;
         @(negedge clk);
         pix_ce   = 1'b0;
      end
   endtask

   task automatic run_frames(input int n, input int hs, input int hb, input int ha, input int hf,
                             input int vs, input int vb, input int va, input int vf);
      for (int f = 0; f < n; f++)
         for (int l = 0; l < vs + vb + va + vf; l++)
            drive_line(hs, hb, ha, hf, l < vs, (l >= vs + vb) && (l < vs + vb + va));
   endtask

   task automatic run_a(input int n);
      run_frames(n, 3, 4, 8, 5, 2, 3, 4, 2);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      read_check("R1 control", 6'h24, 32'h0);
      read_check("R1 mask", 6'h28, 32'hFF);
      read_check("R1 limit", 6'h2C, 32'h1FFF);
      read_check("R1 status", 6'h30, 32'h0);
      read_check("R1 irq status", 6'h00, 32'h0);
      read_check("R1 hactive", 6'h1C, 32'h0);
      check("R1 irq_o", {31'b0, irq_o}, 32'h0);
      reg_write(6'h1C, 32'hFFFF);
      read_check("R13 result write ignored", 6'h1C, 32'h0);
      reg_write(6'h24, 32'hFFFF_FFE0);
      read_check("R13 control unused bits", 6'h24, 32'h0);
      reg_write(6'h28, 32'hFFFF_FF5A);
      read_check("R13 mask unused bits", 6'h28, 32'h5A);
      reg_write(6'h28, 32'hFF);
   endtask

   task automatic t_measure;
      reg_write(6'h24, 32'h04);
      run_a(3);
      read_check("R2 hsync width", 6'h14, 32'd3);
      read_check("R2 hback", 6'h18, 32'd4);
      read_check("R2 hactive", 6'h1C, 32'd8);
      read_check("R2 hfront", 6'h20, 32'd5);
      read_check("R3 vsync width", 6'h04, 32'd2);
      read_check("R3 vback", 6'h08, 32'd3);
      read_check("R3 vactive", 6'h0C, 32'd4);
      read_check("R3 vfront", 6'h10, 32'd2);
      read_check("R12 init done", 6'h30, 32'h2);
      read_check("R7 first refresh sets all", 6'h00, 32'hFF);
      wait_clk(2);
      check("R8 irq off while disabled", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_irq;
      reg_write(6'h24, 32'h0C);
      wait_clk(2);
      check("R8 irq with enable", {31'b0, irq_o}, 32'h1);
      reg_write(6'h28, 32'h00);
      wait_clk(2);
      check("R8 irq masked", {31'b0, irq_o}, 32'h0);
      reg_write(6'h28, 32'hFF);
      reg_write(6'h00, 32'h0F);
      read_check("R7 partial w1c", 6'h00, 32'hF0);
      reg_write(6'h00, 32'hF0);
      read_check("R7 w1c", 6'h00, 32'h0);
      wait_clk(2);
      check("R8 irq after clear", {31'b0, irq_o}, 32'h0);
      run_a(2);
      read_check("R7 repeat sets nothing", 6'h00, 32'h0);
      run_frames(1, 3, 4, 8, 5, 2, 3, 4, 3);
      run_a(1);
      read_check("R3 vfront changed", 6'h10, 32'd3);
      read_check("R7 only vfront bit", 6'h00, 32'h08);
      wait_clk(2);
      check("R8 irq on change", {31'b0, irq_o}, 32'h1);
      reg_write(6'h00, 32'hFF);
   endtask

   task automatic t_polarity;
      hpol = 1'b1; vpol = 1'b1;
      reg_write(6'h24, 32'h07);
      run_frames(3, 2, 3, 6, 4, 3, 2, 5, 3);
      read_check("R4 hsync width inverted", 6'h14, 32'd2);
      read_check("R4 hback inverted", 6'h18, 32'd3);
      read_check("R4 hactive inverted", 6'h1C, 32'd6);
      read_check("R4 hfront inverted", 6'h20, 32'd4);
      read_check("R4 vsync width inverted", 6'h04, 32'd3);
      read_check("R4 vback inverted", 6'h08, 32'd2);
      read_check("R4 vactive inverted", 6'h0C, 32'd5);
      read_check("R4 vfront inverted", 6'h10, 32'd3);
      hpol = 1'b0; vpol = 1'b0;
   endtask

   task automatic t_line_mode;
      reg_write(6'h24, 32'h04);
      run_a(3);
      read_check("R5 baseline hactive", 6'h1C, 32'd8);
      for (int l = 0; l < 3; l++) drive_line(3, 4, 6, 7, 1'b0, 1'b1);
      read_check("R5 frame mode holds hactive", 6'h1C, 32'd8);
      reg_write(6'h24, 32'h14);
      for (int l = 0; l < 3; l++) drive_line(3, 4, 6, 7, 1'b0, 1'b1);
      read_check("R6 line mode hactive", 6'h1C, 32'd6);
      read_check("R6 line mode hfront", 6'h20, 32'd7);
      read_check("R6 vactive unchanged", 6'h0C, 32'd4);
      reg_write(6'h24, 32'h04);
   endtask

   task automatic t_timeout;
      logic [31:0] d;
      reg_write(6'h2C, 32'd20);
      read_check("R10 limit stored", 6'h2C, 32'd20);
      @(negedge clk); hsync_in = 1'b1;
      wait_clk(3);
      reg_write(6'h30, 32'h1);
      @(negedge clk); hsync_in = 1'b0;
      wait_clk(20);
      hsync_in = 1'b1;
      wait_clk(3);
      reg_read(6'h30, d);
      check("R9 run equal to limit", {31'b0, d[0]}, 32'h0);
      @(negedge clk); hsync_in = 1'b0;
      wait_clk(21);
      hsync_in = 1'b1;
      wait_clk(3);
      reg_read(6'h30, d);
      check("R9 run above limit", {31'b0, d[0]}, 32'h1);
      wait_clk(5);
      reg_read(6'h30, d);
      check("R9 flag sticky", {31'b0, d[0]}, 32'h1);
      reg_write(6'h2C, 32'h0);
      read_check("R10 zero write ignored", 6'h2C, 32'd20);
      reg_write(6'h30, 32'h1);
      reg_read(6'h30, d);
      check("R9 w1c", {31'b0, d[0]}, 32'h0);
      reg_write(6'h2C, 32'h1FFF);
   endtask

   task automatic t_disable;
      logic [31:0] d;
      reg_write(6'h24, 32'h00);
      reg_read(6'h30, d);
      check("R11 init cleared when off", {31'b0, d[1]}, 32'h0);
      reg_write(6'h24, 32'h04);
      run_a(1);
      reg_read(6'h30, d);
      check("R12 one frame not enough", {31'b0, d[1]}, 32'h0);
      run_a(1);
      reg_read(6'h30, d);
      check("R12 second frame completes", {31'b0, d[1]}, 32'h1);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_measure();
      t_irq();
      t_polarity();
      t_line_mode();
      t_timeout();
      t_disable();
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule